// File: doc/BRIEF.md
# Vector Lane Permute Unit

This block rearranges the lanes of 128-bit vectors. One operation is issued per clock and its result appears on registered outputs one cycle later. Lanes are 8, 16, 32 or 64 bits wide, and the lane width is picked per operation. Six operations are supported. Swizzle reorders the lanes of one vector. Shuffle picks lanes out of the concatenation of two vectors. Select merges two vectors lane by lane under a mask. Extract reads one lane out to a scalar. Replace writes a scalar into one lane. Splat copies a scalar into every lane.

Lane indices are supplied as sixteen packed 5-bit entries. Lane-indexed operations read entry i for output lane i. Extract and replace use entry 0 alone. An index that points outside the legal range raises an error flag, and the output lane it would have filled is set to zero. The datapath holds no state across operations, so there are no states and no transitions to list. The only sequential element is the output register stage.

Top module: `vperm_unit`

## Requirements
- R1: While rst_n is low, vec_o, scal_o and idx_err_o are all zero.
- R2: The result of an operation presented before a rising clock edge appears on the outputs directly after that edge, so the latency is one cycle. Operation codes: 0 swizzle, 1 shuffle, 2 select, 3 extract, 4 replace, 5 splat. Codes 6 and 7 drive every output to zero. Lane size codes: 0 is 8 bits, 1 is 16, 2 is 32, 3 is 64. The lane count L is 16, 8, 4 or 2 respectively.
- R3: Swizzle sets output lane i to lane idx[i] of va, where idx[i] is bits [5i+4:5i] of idx_i.
- R4: Shuffle sets output lane i to va lane idx[i] when idx[i] < L. When L <= idx[i] < 2L it takes vb lane idx[i]-L instead. With 8-bit lanes every 5-bit index from 0 to 31 is legal.
- R5: In a swizzle or shuffle, an index at or above the legal bound (L or 2L) makes its output lane zero and raises idx_err_o. Index entries at positions L and above are ignored.
- R6: Select takes output lane i from va when bit i of mask_i is set and from vb otherwise. Mask bits at positions L and above are ignored.
- R7: Extract returns lane idx[0] of va on scal_o. For 8-bit and 16-bit lanes the value is sign-extended to 32 bits when sgn_i is 1 and zero-extended when it is 0. A 32-bit lane is returned unchanged. In all three of these cases bits 63:32 are zero. A 64-bit lane fills all of scal_o. During extract, vec_o is zero.
- R8: If idx[0] >= L during an extract, scal_o is zero and idx_err_o is set.
- R9: Replace copies va and overwrites lane idx[0] with the low lane-width bits of scalar_i. If idx[0] >= L, va passes through unchanged and idx_err_o is set.
- R10: Splat fills every lane with the low lane-width bits of scalar_i.
- R11: For every operation except extract, scal_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| lsz_i | input | 2 | Lane size code |
| sgn_i | input | 1 | Extract: 1 sign-extends, 0 zero-extends |
| va_i | input | 128 | First source vector (true side for select) |
| vb_i | input | 128 | Second source vector (false side for select) |
| idx_i | input | 80 | Sixteen packed 5-bit lane indices |
| mask_i | input | 16 | Per-lane select mask, lane i in bit i |
| scalar_i | input | 64 | Scalar for replace and splat |
| vec_o | output | 128 | Vector result |
| scal_o | output | 64 | Scalar result of extract |
| idx_err_o | output | 1 | Out-of-range index seen |

## Verification
Several corner cases are targeted directly, each with the failure it would expose. Shuffle with 8-bit lanes uses index 31: a unit that compared against the single-source bound would flag an error and zero those lanes. A 32-bit swizzle carries all-ones garbage in its unused index entries, which catches a checker that scans all sixteen entries. Extract reads a lane whose top bit is set, once signed and once unsigned, which exposes extension errors and any leakage into bits 63:32. Replace and splat use scalars with their high bits set, which shows any lane that picks up bits it should discard. An out-of-range replace must leave va intact.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

    localparam int VBYTES = 16;
    localparam int IDX_W  = 5;
    localparam int SCAL_W = 64;

    typedef enum logic [2:0] {
        OP_SWIZZLE = 3'd0,
        OP_SHUFFLE = 3'd1,
        OP_SELECT  = 3'd2,
        OP_EXTRACT = 3'd3,
        OP_REPLACE = 3'd4,
        OP_SPLAT   = 3'd5,
        OP_RSV6    = 3'd6,
        OP_RSV7    = 3'd7
    } perm_op_e;

endpackage

// File: rtl/vperm_route.sv
module vperm_route
    import vperm_pkg::*;
#(
    parameter int NB = VBYTES,
    parameter int IW = IDX_W,
    parameter int SW = SCAL_W
) (
    input  perm_op_e          op,
    input  logic [1:0]        lsz,
    input  logic [NB*8-1:0]   va,
    input  logic [NB*8-1:0]   vb,
    input  logic [NB*IW-1:0]  idx,
    input  logic [NB-1:0]     mask,
    input  logic [SW-1:0]     scal,
    output logic [NB*8-1:0]   vout,
    output logic              err
);
    localparam int VW = NB * 8;

    logic [2*VW-1:0] pair;
    assign pair = {vb, va};

    always_comb begin
        int lanes;
        int lb;
        int ln;
        int off;
        int ix;
        int ix0;
        lanes = NB >> lsz;
        lb    = 1 << lsz;
        ix0   = int'(idx[IW-1:0]);
        vout  = '0;
        err   = 1'b0;
        for (int b = 0; b < NB; b++) begin
            ln  = b >> lsz;
            off = b & (lb - 1);
            ix  = int'(idx[ln*IW +: IW]);
            unique case (op)
                OP_SWIZZLE: begin
                    if (ix < lanes) vout[b*8 +: 8] = va[(ix*lb + off)*8 +: 8];
                    else            err = 1'b1;
                end
                OP_SHUFFLE: begin
                    if (ix < 2*lanes) vout[b*8 +: 8] = pair[(ix*lb + off)*8 +: 8];
                    else              err = 1'b1;
                end
                OP_SELECT: begin
                    vout[b*8 +: 8] = mask[ln] ? va[b*8 +: 8] : vb[b*8 +: 8];
                end
                OP_REPLACE: begin
                    vout[b*8 +: 8] = (ln == ix0) ? scal[off*8 +: 8] : va[b*8 +: 8];
                end
                OP_SPLAT: begin
                    vout[b*8 +: 8] = scal[off*8 +: 8];
                end
                default: vout[b*8 +: 8] = 8'h00;
            endcase
        end
        if (op == OP_REPLACE && ix0 >= lanes) err = 1'b1;
    end

endmodule

// File: rtl/vperm_extract.sv
module vperm_extract
    import vperm_pkg::*;
#(
    parameter int NB = VBYTES,
    parameter int IW = IDX_W,
    parameter int SW = SCAL_W
) (
    input  logic [1:0]       lsz,
    input  logic             sgn,
    input  logic [NB*8-1:0]  va,
    input  logic [IW-1:0]    ix0,
    output logic [SW-1:0]    sout,
    output logic             err
);
    localparam int HW = SW / 2;

    always_comb begin
        logic [7:0]  b8;
        logic [15:0] b16;
        int lanes;
        int ix;
        lanes = NB >> lsz;
        ix    = int'(ix0);
        sout  = '0;
        err   = 1'b0;
        b8    = '0;
        b16   = '0;
        if (ix >= lanes) begin
            err = 1'b1;
        end else begin
            unique case (lsz)
                2'd0: begin
                    b8   = va[ix*8 +: 8];
                    sout = {{HW{1'b0}}, {(HW-8){sgn & b8[7]}}, b8};
                end
                2'd1: begin
                    b16  = va[ix*16 +: 16];
                    sout = {{HW{1'b0}}, {(HW-16){sgn & b16[15]}}, b16};
                end
                2'd2: sout = {{HW{1'b0}}, va[ix*32 +: 32]};
                default: sout = va[ix*64 +: 64];
            endcase
        end
    end

endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
    import vperm_pkg::*;
#(
    parameter int NB = VBYTES,
    parameter int IW = IDX_W,
    parameter int SW = SCAL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         op_i,
    input  logic [1:0]         lsz_i,
    input  logic               sgn_i,
    input  logic [NB*8-1:0]    va_i,
    input  logic [NB*8-1:0]    vb_i,
    input  logic [NB*IW-1:0]   idx_i,
    input  logic [NB-1:0]      mask_i,
    input  logic [SW-1:0]      scalar_i,
    output logic [NB*8-1:0]    vec_o,
    output logic [SW-1:0]      scal_o,
    output logic               idx_err_o
);
    localparam int VW = NB * 8;

    perm_op_e        op_e;
    logic [VW-1:0]   route_v;
    logic            route_err;
    logic [SW-1:0]   ext_s;
    logic            ext_err;
    logic            live_q;

    assign op_e = perm_op_e'(op_i);

    vperm_route #(.NB(NB), .IW(IW), .SW(SW)) u_route (
        .op   (op_e),
        .lsz  (lsz_i),
        .va   (va_i),
        .vb   (vb_i),
        .idx  (idx_i),
        .mask (mask_i),
        .scal (scalar_i),
        .vout (route_v),
        .err  (route_err)
    );

    vperm_extract #(.NB(NB), .IW(IW), .SW(SW)) u_ext (
        .lsz  (lsz_i),
        .sgn  (sgn_i),
        .va   (va_i),
        .ix0  (idx_i[IW-1:0]),
        .sout (ext_s),
        .err  (ext_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_o     <= '0;
            scal_o    <= '0;
            idx_err_o <= 1'b0;
            live_q    <= 1'b0;
        end else begin
            live_q <= 1'b1;
            if (op_e == OP_EXTRACT) begin
                vec_o     <= '0;
                scal_o    <= ext_s;
                idx_err_o <= ext_err;
            end else begin
                vec_o     <= route_v;
                scal_o    <= '0;
                idx_err_o <= route_err;
            end
        end
    end

    // R4: shuffle of 8-bit lanes can never go out of range
    p_shuf8_no_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_SHUFFLE && lsz_i == 2'd0) |=> !idx_err_o);

    // R6: select has no index and never flags an error
    p_select_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_SELECT) |=> !idx_err_o);

    // R7: extract leaves the vector output clear
    p_extract_vec_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_EXTRACT) |=> (vec_o == '0));

    // R9: replace of 64-bit lane 0 keeps the upper lane of va
    p_replace_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_REPLACE && lsz_i == 2'd3 && idx_i[IW-1:0] == '0)
        |=> (vec_o[VW-1:64] == $past(va_i[VW-1:64])));

    // R10: byte splat yields identical bytes
    p_splat8_uniform_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_SPLAT && lsz_i == 2'd0) |=> (vec_o == {NB{vec_o[7:0]}}));

    // R11: scalar output is clear for all non-extract operations
    p_scal_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && op_e != OP_EXTRACT) |=> (scal_o == '0));

endmodule

// File: tb/tb_vperm_unit.sv
module tb_vperm_unit;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_i = '0;
    logic [1:0]   lsz_i = '0;
    logic         sgn_i = 1'b0;
    logic [127:0] va_i = '0;
    logic [127:0] vb_i = '0;
    logic [79:0]  idx_i = '0;
    logic [15:0]  mask_i = '0;
    logic [63:0]  scalar_i = '0;
    logic [127:0] vec_o;
    logic [63:0]  scal_o;
    logic         idx_err_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vperm_unit dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .lsz_i(lsz_i), .sgn_i(sgn_i),
        .va_i(va_i), .vb_i(vb_i), .idx_i(idx_i), .mask_i(mask_i),
        .scalar_i(scalar_i), .vec_o(vec_o), .scal_o(scal_o), .idx_err_o(idx_err_o)
    );

    function automatic logic [63:0] lget(logic [127:0] v, int sz, int i);
        logic [63:0] r = '0;
        int w = 8 << sz;
        for (int k = 0; k < w; k++) r[k] = v[i*w + k];
        return r;
    endfunction

    function automatic logic [127:0] lput(logic [127:0] v, int sz, int i, logic [63:0] x);
        int w = 8 << sz;
        for (int k = 0; k < w; k++) v[i*w + k] = x[k];
        return v;
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic set_idx(int e, int val);
        idx_i[e*5 +: 5] = val[4:0];
    endtask

    // R2: inputs applied at a falling edge are seen after exactly one rising edge
    task automatic issue(logic [2:0] o, logic [1:0] s, logic sg);
        op_i = o; lsz_i = s; sgn_i = sg;
        @(negedge clk);
    endtask

    task automatic fill_vectors();
        for (int b = 0; b < 16; b++) begin
            va_i[b*8 +: 8] = 8'(8'h10 + b);
            vb_i[b*8 +: 8] = 8'(8'hA0 + b);
        end
    endtask

    task automatic t_reset();
        chk("R1 vec", vec_o, '0);
        chk("R1 scal", {64'h0, scal_o}, '0);
        chk("R1 err", {127'h0, idx_err_o}, '0);
    endtask

    task automatic t_swizzle();
        logic [127:0] e = '0;
        fill_vectors();
        for (int i = 0; i < 4; i++) set_idx(i, 3 - i);
        for (int i = 4; i < 16; i++) set_idx(i, 31);   // R5 ignored entries
        issue(3'd0, 2'd2, 1'b0);
        for (int i = 0; i < 4; i++) e = lput(e, 2, i, lget(va_i, 2, 3 - i));
        chk("R3 swizzle32", vec_o, e);
        chk("R5 unused entries", {127'h0, idx_err_o}, '0);
        chk("R11 scal after swizzle", {64'h0, scal_o}, '0);
        e = '0;
        for (int i = 0; i < 16; i++) set_idx(i, (i + 5) % 16);
        issue(3'd0, 2'd0, 1'b0);
        for (int i = 0; i < 16; i++) e = lput(e, 0, i, lget(va_i, 0, (i + 5) % 16));
        chk("R3 swizzle8", vec_o, e);
    endtask

    task automatic t_shuffle();
        int s16[8] = '{9, 0, 15, 3, 8, 7, 12, 1};
        logic [127:0] e = '0;
        fill_vectors();
        for (int i = 0; i < 8; i++) set_idx(i, s16[i]);
        issue(3'd1, 2'd1, 1'b0);
        for (int i = 0; i < 8; i++)
            e = lput(e, 1, i, s16[i] < 8 ? lget(va_i, 1, s16[i]) : lget(vb_i, 1, s16[i] - 8));
        chk("R4 shuffle16", vec_o, e);
        e = '0;
        for (int i = 0; i < 16; i++) set_idx(i, 31 - i);
        issue(3'd1, 2'd0, 1'b0);
        for (int i = 0; i < 16; i++) e = lput(e, 0, i, lget(vb_i, 0, 15 - i));
        chk("R4 shuffle8 idx31", vec_o, e);
        chk("R4 shuffle8 no err", {127'h0, idx_err_o}, '0);
    endtask

    task automatic t_range();
        logic [127:0] e = '0;
        fill_vectors();
        idx_i = '0; set_idx(0, 1); set_idx(1, 2);
        issue(3'd0, 2'd3, 1'b0);
        e = lput(e, 3, 0, lget(va_i, 3, 1));
        chk("R5 swizzle64 oor lane", vec_o, e);
        chk("R5 swizzle64 err", {127'h0, idx_err_o}, 128'h1);
        e = '0;
        set_idx(0, 4); set_idx(1, 3);
        issue(3'd1, 2'd3, 1'b0);
        e = lput(e, 3, 1, lget(vb_i, 3, 1));
        chk("R5 shuffle64 oor", vec_o, e);
        chk("R5 shuffle64 err", {127'h0, idx_err_o}, 128'h1);
    endtask

    task automatic t_select();
        logic [127:0] e = '0;
        fill_vectors();
        mask_i = 16'hFF5A;
        issue(3'd2, 2'd1, 1'b0);
        for (int i = 0; i < 8; i++)
            e = lput(e, 1, i, mask_i[i] ? lget(va_i, 1, i) : lget(vb_i, 1, i));
        chk("R6 select16", vec_o, e);
        chk("R6 select err", {127'h0, idx_err_o}, '0);
    endtask

    task automatic t_extract();
        va_i = '0;
        va_i = lput(va_i, 0, 5, 64'h80);
        idx_i = '0; set_idx(0, 5);
        issue(3'd3, 2'd0, 1'b1);
        chk("R7 ext8 signed", {64'h0, scal_o}, {64'h0, 64'h0000_0000_FFFF_FF80});
        chk("R7 vec zero", vec_o, '0);
        issue(3'd3, 2'd0, 1'b0);
        chk("R7 ext8 unsigned", {64'h0, scal_o}, 128'h80);
        va_i = lput(va_i, 1, 6, 64'h8001); set_idx(0, 6);
        issue(3'd3, 2'd1, 1'b1);
        chk("R7 ext16 signed", {64'h0, scal_o}, 128'hFFFF_8001);
        issue(3'd3, 2'd1, 1'b0);
        chk("R7 ext16 unsigned", {64'h0, scal_o}, 128'h8001);
        va_i = lput(va_i, 2, 2, 64'h8000_0001); set_idx(0, 2);
        issue(3'd3, 2'd2, 1'b1);
        chk("R7 ext32", {64'h0, scal_o}, 128'h8000_0001);
        va_i = lput(va_i, 3, 1, 64'hFEDC_BA98_7654_3210); set_idx(0, 1);
        issue(3'd3, 2'd3, 1'b0);
        chk("R7 ext64", {64'h0, scal_o}, {64'h0, 64'hFEDC_BA98_7654_3210});
        set_idx(0, 4);
        issue(3'd3, 2'd2, 1'b0);
        chk("R8 ext oor scal", {64'h0, scal_o}, '0);
        chk("R8 ext oor err", {127'h0, idx_err_o}, 128'h1);
    endtask

    task automatic t_replace();
        fill_vectors();
        scalar_i = 64'h1111_2222_DEAD_BEEF;
        idx_i = '0; set_idx(0, 3);
        issue(3'd4, 2'd1, 1'b0);
        chk("R9 replace16", vec_o, lput(va_i, 1, 3, 64'hBEEF));
        scalar_i = 64'h1FF; set_idx(0, 15);
        issue(3'd4, 2'd0, 1'b0);
        chk("R9 replace8 lane15", vec_o, lput(va_i, 0, 15, 64'hFF));
        set_idx(0, 2);
        issue(3'd4, 2'd3, 1'b0);
        chk("R9 replace oor passthru", vec_o, va_i);
        chk("R9 replace oor err", {127'h0, idx_err_o}, 128'h1);
    endtask

    task automatic t_splat();
        scalar_i = 64'h0000_0000_0000_1234;
        issue(3'd5, 2'd0, 1'b0);
        chk("R10 splat8", vec_o, {16{8'h34}});
        scalar_i = 64'h0123_4567_89AB_CDEF;
        issue(3'd5, 2'd3, 1'b0);
        chk("R10 splat64", vec_o, {2{64'h0123_4567_89AB_CDEF}});
        issue(3'd5, 2'd2, 1'b0);
        chk("R10 splat32", vec_o, {4{32'h89AB_CDEF}});
    endtask

    task automatic t_reserved();
        fill_vectors();
        idx_i = '1;
        issue(3'd7, 2'd0, 1'b0);
        chk("R2 reserved vec", vec_o, '0);
        chk("R11 reserved scal", {64'h0, scal_o}, '0);
        chk("R2 reserved err", {127'h0, idx_err_o}, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_swizzle();
        t_shuffle();
        t_range();
        t_select();
        t_extract();
        t_replace();
        t_splat();
        t_reserved();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule